// File: doc/BRIEF.md
# Retirement Trace Event Generator

This block sits next to a simple in-order RISC-V core. Each cycle it takes the core's indications and turns them into one registered trace event for a verification environment. The core reports how many instructions retired, whether a synchronous exception was raised, whether a trap handler was entered, whether the hart halted, its program counter, its privilege level and a set of CSR write ports. The event carries valid, trap, intr and halt flags, the PC, the privilege field, a retirement count and a CSR write mask with one bit per CSR address.

A small control state machine tracks handler entry and halting. It has three states: `ST_RUN` (normal), `ST_PEND` (a handler entry was seen and the next retirement must carry intr) and `ST_HALT` (the hart has halted and no events are emitted). The transitions are named as follows. RUN→PEND on handler entry. PEND→RUN on a retirement with no new handler entry. PEND→PEND on a trap event or a repeated entry. RUN/PEND→HALT on any event flagged with halt. HALT→HALT until reset. Reset returns the machine to RUN.

Top module: `retire_trace`

## Requirements
- R1: A synchronous reset (`rst` high) clears tr_valid, tr_trap, tr_intr, tr_halt, tr_count and tr_csr_mask, and discards any pending handler-entry mark, so the first retirement after reset has tr_intr low.
- R2: Every trace output is registered: the inputs present at one rising edge appear on the outputs just after that edge. A retirement (core_ret_cnt nonzero, core_exc low) gives tr_valid=1, tr_trap=0, and tr_pc equal to the core's PC.
- R3: When core_exc is high, the event has tr_valid=1 and tr_trap=1, tr_pc equal to the PC of the faulting instruction, and tr_count=0. This holds whatever core_ret_cnt is.
- R4: Handler entry (core_hentry) without core_exc never raises tr_trap. If nothing retired in that cycle, tr_valid stays low.
- R5: After a handler entry, tr_intr is raised on the first later retirement and on no other event. A retirement in the same cycle as the entry does not carry it.
- R6: A trap event does not consume a pending handler-entry mark. The mark survives any number of trap events and is shown on the next retirement.
- R7: tr_csr_mask bit n is set when any enabled write port carries CSR address n. Two ports may set two bits, or the same bit. An address at or above NCSR is ignored. With no write enabled, the mask is zero.
- R8: tr_priv forwards the privilege level in the standard encoding: 2'b11 machine, 2'b01 supervisor, 2'b00 user.
- R9: tr_count reports the retirement count of a retirement event, clamped to NRET when core_ret_cnt exceeds it.
- R10: An event with core_halt high is reported with tr_halt=1. After that, no further event is reported (valid, trap and intr stay low, and handler entry is ignored) until reset.
- R11: In a cycle with no event, tr_valid, tr_trap, tr_intr and tr_halt are low, and tr_count and tr_csr_mask are zero, even if CSR write ports are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| core_ret_cnt | input | RCW | Instructions retired this cycle |
| core_exc | input | 1 | Synchronous exception on the instruction at core_pc |
| core_hentry | input | 1 | Trap handler entered this cycle |
| core_halt | input | 1 | Hart halts at this cycle's instruction |
| core_pc | input | XLEN | PC of the reported instruction |
| core_priv | input | 2 | Current privilege level |
| core_csr_we | input | NWP | Write enable per CSR write port |
| core_csr_addr | input | NWP*12 | Packed 12-bit CSR address per write port, port 0 in the low bits |
| tr_valid | output | 1 | Event present |
| tr_trap | output | 1 | Event is a synchronous exception |
| tr_intr | output | 1 | First retirement of a trap handler |
| tr_halt | output | 1 | Hart halted at this event |
| tr_pc | output | XLEN | Registered PC |
| tr_priv | output | 2 | Registered privilege level |
| tr_count | output | RCW | Retirements in this event |
| tr_csr_mask | output | NCSR | One bit per CSR address written |

## Verification
The bench drives a plain retirement in each privilege level. This separates the forwarded payload from the flags. An exception with handler entry is followed by a second exception and then a retirement, which shows whether traps wrongly consume or expose the intr mark. An entry without an exception, and an entry that shares a cycle with a retirement, tell the interrupt path apart from the trap path. They also show whether the mark is applied one retirement too early. CSR tests use distinct addresses, a repeated address, an out-of-range address and writes in idle cycles. Oversized retirement counts and a halt followed by traffic and reset exercise the clamp and the terminal state.

// File: rtl/trc_pkg.sv
package trc_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_PEND = 2'd1,
        ST_HALT = 2'd2
    } trc_state_e;

    typedef struct packed {
        logic valid;
        logic trap;
        logic intr;
        logic halt;
    } trc_flags_t;

    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_S = 2'b01;
    localparam logic [1:0] PRIV_M = 2'b11;

    localparam int CSR_AW = 12;

endpackage

// File: rtl/trc_csr_decode.sv
module trc_csr_decode
    import trc_pkg::*;
#(
    parameter int NCSR = 64,
    parameter int NWP  = 2
) (
    input  logic [NWP-1:0]        we,
    input  logic [NWP*CSR_AW-1:0] addr,
    output logic [NCSR-1:0]       mask
);

    localparam int IW = (NCSR > 1) ? $clog2(NCSR) : 1;

    logic [NWP:0][NCSR-1:0] acc;

    assign acc[0] = '0;

    for (genvar p = 0; p < NWP; p++) begin : g_port
        logic [CSR_AW-1:0] a;
        logic [NCSR-1:0]   one;
        assign a = addr[p*CSR_AW +: CSR_AW];
        always_comb begin
            one = '0;
            if (we[p] && (32'(a) < NCSR)) begin
                one[a[IW-1:0]] = 1'b1;
            end
        end
        assign acc[p+1] = acc[p] | one;
    end

    assign mask = acc[NWP];

endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl
    import trc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ev_ret,
    input  logic       ev_trap,
    input  logic       hentry,
    input  logic       halt_in,
    output trc_flags_t flags_d
);

    trc_state_e state, state_nxt;
    logic       ev_any;

    assign ev_any = ev_ret | ev_trap;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN: begin
                if (ev_any && halt_in)  state_nxt = ST_HALT;
                else if (hentry)        state_nxt = ST_PEND;
                else                    state_nxt = ST_RUN;
            end
            ST_PEND: begin
                if (ev_any && halt_in)      state_nxt = ST_HALT;
                else if (ev_ret && !hentry) state_nxt = ST_RUN;
                else                        state_nxt = ST_PEND;
            end
            ST_HALT: state_nxt = ST_HALT;
            default: state_nxt = ST_RUN;
        endcase
    end

    always_comb begin
        flags_d = '0;
        unique case (state)
            ST_RUN: begin
                flags_d.valid = ev_any;
                flags_d.trap  = ev_trap;
                flags_d.halt  = ev_any & halt_in;
            end
            ST_PEND: begin
                flags_d.valid = ev_any;
                flags_d.trap  = ev_trap;
                flags_d.intr  = ev_ret;
                flags_d.halt  = ev_any & halt_in;
            end
            ST_HALT: flags_d = '0;
            default: flags_d = '0;
        endcase
    end

endmodule

// File: rtl/trc_out_reg.sv
module trc_out_reg
    import trc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int RCW  = 2,
    parameter int NCSR = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  trc_flags_t      flags_d,
    input  logic [XLEN-1:0] pc_d,
    input  logic [1:0]      priv_d,
    input  logic [RCW-1:0]  cnt_d,
    input  logic [NCSR-1:0] mask_d,
    output trc_flags_t      flags_q,
    output logic [XLEN-1:0] pc_q,
    output logic [1:0]      priv_q,
    output logic [RCW-1:0]  cnt_q,
    output logic [NCSR-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            pc_q    <= '0;
            priv_q  <= PRIV_M;
            cnt_q   <= '0;
            mask_q  <= '0;
        end else begin
            flags_q <= flags_d;
            pc_q    <= pc_d;
            priv_q  <= priv_d;
            cnt_q   <= cnt_d;
            mask_q  <= mask_d;
        end
    end

endmodule

// File: rtl/retire_trace.sv
module retire_trace
    import trc_pkg::*;
#(
    parameter int NRET = 2,
    parameter int XLEN = 32,
    parameter int NCSR = 64,
    parameter int NWP  = 2,
    localparam int RCW = $clog2(NRET + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [RCW-1:0]        core_ret_cnt,
    input  logic                  core_exc,
    input  logic                  core_hentry,
    input  logic                  core_halt,
    input  logic [XLEN-1:0]       core_pc,
    input  logic [1:0]            core_priv,
    input  logic [NWP-1:0]        core_csr_we,
    input  logic [NWP*CSR_AW-1:0] core_csr_addr,
    output logic                  tr_valid,
    output logic                  tr_trap,
    output logic                  tr_intr,
    output logic                  tr_halt,
    output logic [XLEN-1:0]       tr_pc,
    output logic [1:0]            tr_priv,
    output logic [RCW-1:0]        tr_count,
    output logic [NCSR-1:0]       tr_csr_mask
);

    localparam logic [RCW-1:0] CNT_MAX = RCW'(NRET);

    logic [RCW-1:0]  cnt_c;
    logic            ev_ret;
    logic [NCSR-1:0] mask_raw;
    logic [NCSR-1:0] mask_d;
    logic [RCW-1:0]  cnt_d;
    trc_flags_t      flags_d;
    trc_flags_t      flags_q;

    assign cnt_c  = (core_ret_cnt > CNT_MAX) ? CNT_MAX : core_ret_cnt;
    assign ev_ret = (cnt_c != '0) && !core_exc;

    trc_csr_decode #(
        .NCSR (NCSR),
        .NWP  (NWP)
    ) u_dec (
        .we   (core_csr_we),
        .addr (core_csr_addr),
        .mask (mask_raw)
    );

    trc_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ev_ret  (ev_ret),
        .ev_trap (core_exc),
        .hentry  (core_hentry),
        .halt_in (core_halt),
        .flags_d (flags_d)
    );

    assign cnt_d  = (flags_d.valid && !flags_d.trap) ? cnt_c : '0;
    assign mask_d = flags_d.valid ? mask_raw : '0;

    trc_out_reg #(
        .XLEN (XLEN),
        .RCW  (RCW),
        .NCSR (NCSR)
    ) u_oreg (
        .clk     (clk),
        .rst     (rst),
        .flags_d (flags_d),
        .pc_d    (core_pc),
        .priv_d  (core_priv),
        .cnt_d   (cnt_d),
        .mask_d  (mask_d),
        .flags_q (flags_q),
        .pc_q    (tr_pc),
        .priv_q  (tr_priv),
        .cnt_q   (tr_count),
        .mask_q  (tr_csr_mask)
    );

    assign tr_valid = flags_q.valid;
    assign tr_trap  = flags_q.trap;
    assign tr_intr  = flags_q.intr;
    assign tr_halt  = flags_q.halt;

endmodule

// File: rtl/retire_trace_chk.sv
module retire_trace_chk #(
    parameter int NRET = 2,
    parameter int XLEN = 32,
    parameter int NCSR = 64,
    parameter int RCW  = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            core_exc,
    input logic [XLEN-1:0] core_pc,
    input logic            tr_valid,
    input logic            tr_trap,
    input logic            tr_intr,
    input logic            tr_halt,
    input logic [XLEN-1:0] tr_pc,
    input logic [RCW-1:0]  tr_count,
    input logic [NCSR-1:0] tr_csr_mask
);

    logic halt_seen;

    always_ff @(posedge clk) begin
        if (rst)          halt_seen <= 1'b0;
        else if (tr_halt) halt_seen <= 1'b1;
    end

    // R3: a trap is always a valid event
    a_r3_trap_is_valid: assert property (@(posedge clk) disable iff (rst)
        tr_trap |-> tr_valid);

    // R3: the trap PC is the PC of the faulting instruction
    a_r3_trap_pc: assert property (@(posedge clk) disable iff (rst)
        tr_trap |-> (tr_pc == $past(core_pc)));

    // R4: no trap without an exception from the core
    a_r4_trap_needs_exc: assert property (@(posedge clk) disable iff (rst)
        tr_trap |-> $past(core_exc));

    // R5: intr only on a retirement event
    a_r5_intr_on_retire: assert property (@(posedge clk) disable iff (rst)
        tr_intr |-> (tr_valid && !tr_trap));

    // R9: the count never exceeds the limit
    a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
        tr_count <= RCW'(NRET));

    // R10: silence after halt until reset
    a_r10_silent_after_halt: assert property (@(posedge clk) disable iff (rst)
        halt_seen |-> !tr_valid);

    // R11: no payload without an event
    a_r11_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !tr_valid |-> (tr_csr_mask == '0 && tr_count == '0 && !tr_halt));

endmodule

bind retire_trace retire_trace_chk #(
    .NRET (NRET),
    .XLEN (XLEN),
    .NCSR (NCSR),
    .RCW  (RCW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .core_exc    (core_exc),
    .core_pc     (core_pc),
    .tr_valid    (tr_valid),
    .tr_trap     (tr_trap),
    .tr_intr     (tr_intr),
    .tr_halt     (tr_halt),
    .tr_pc       (tr_pc),
    .tr_count    (tr_count),
    .tr_csr_mask (tr_csr_mask)
);

// File: tb/tb_retire_trace.sv
`timescale 1ns/100ps
module tb_retire_trace;
    import trc_pkg::*;

    localparam int NRET = 2;
    localparam int XLEN = 32;
    localparam int NCSR = 64;
    localparam int NWP  = 2;
    localparam int RCW  = $clog2(NRET + 1);

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [RCW-1:0]        core_ret_cnt = '0;
    logic                  core_exc = 1'b0;
    logic                  core_hentry = 1'b0;
    logic                  core_halt = 1'b0;
    logic [XLEN-1:0]       core_pc = '0;
    logic [1:0]            core_priv = PRIV_M;
    logic [NWP-1:0]        core_csr_we = '0;
    logic [NWP*CSR_AW-1:0] core_csr_addr = '0;
    logic                  tr_valid, tr_trap, tr_intr, tr_halt;
    logic [XLEN-1:0]       tr_pc;
    logic [1:0]            tr_priv;
    logic [RCW-1:0]        tr_count;
    logic [NCSR-1:0]       tr_csr_mask;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    retire_trace #(.NRET(NRET), .XLEN(XLEN), .NCSR(NCSR), .NWP(NWP)) dut (
        .clk(clk), .rst(rst), .core_ret_cnt(core_ret_cnt), .core_exc(core_exc),
        .core_hentry(core_hentry), .core_halt(core_halt), .core_pc(core_pc),
        .core_priv(core_priv), .core_csr_we(core_csr_we), .core_csr_addr(core_csr_addr),
        .tr_valid(tr_valid), .tr_trap(tr_trap), .tr_intr(tr_intr), .tr_halt(tr_halt),
        .tr_pc(tr_pc), .tr_priv(tr_priv), .tr_count(tr_count), .tr_csr_mask(tr_csr_mask)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic flags(string req, bit v, bit t, bit i, bit h);
        chk(req, "valid", 64'(tr_valid), 64'(v));
        chk(req, "trap",  64'(tr_trap),  64'(t));
        chk(req, "intr",  64'(tr_intr),  64'(i));
        chk(req, "halt",  64'(tr_halt),  64'(h));
    endtask

    task automatic idle();
        core_ret_cnt = '0; core_exc = 0; core_hentry = 0; core_halt = 0;
        core_csr_we = '0; core_csr_addr = '0;
    endtask

    task automatic drive(int cnt, bit exc, bit hen, bit hlt, logic [XLEN-1:0] pc, logic [1:0] pv);
        core_ret_cnt = RCW'(cnt); core_exc = exc; core_hentry = hen;
        core_halt = hlt; core_pc = pc; core_priv = pv;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1; drive(1, 0, 1, 0, 32'h10, PRIV_M); tick(); tick();
        flags("R1", 0, 0, 0, 0);
        chk("R1", "mask", 64'(tr_csr_mask), 64'h0);
        chk("R1", "count", 64'(tr_count), 64'h0);
        rst = 0; drive(0, 0, 1, 0, 32'h14, PRIV_M); tick();
        rst = 1; idle(); tick();
        rst = 0; drive(1, 0, 0, 0, 32'h18, PRIV_M); tick();
        flags("R1", 1, 0, 0, 0);
        idle(); tick();
    endtask

    task automatic t_retire();
        drive(1, 0, 0, 0, 32'h100, PRIV_M); tick();
        flags("R2", 1, 0, 0, 0);
        chk("R2", "pc", 64'(tr_pc), 64'h100);
        chk("R8", "priv M", 64'(tr_priv), 64'h3);
        chk("R2", "count", 64'(tr_count), 64'h1);
        drive(1, 0, 0, 0, 32'h104, PRIV_S); tick();
        chk("R8", "priv S", 64'(tr_priv), 64'h1);
        chk("R2", "pc", 64'(tr_pc), 64'h104);
        drive(2, 0, 0, 0, 32'h108, PRIV_U); tick();
        chk("R8", "priv U", 64'(tr_priv), 64'h0);
        chk("R2", "count 2", 64'(tr_count), 64'h2);
        idle(); tick();
        flags("R11", 0, 0, 0, 0);
        chk("R11", "count", 64'(tr_count), 64'h0);
    endtask

    task automatic t_trap();
        drive(1, 1, 0, 0, 32'h200, PRIV_M); tick();
        flags("R3", 1, 1, 0, 0);
        chk("R3", "pc", 64'(tr_pc), 64'h200);
        chk("R3", "count", 64'(tr_count), 64'h0);
        idle(); tick();
    endtask

    task automatic t_async();
        drive(0, 0, 1, 0, 32'h300, PRIV_U); tick();
        flags("R4", 0, 0, 0, 0);
        drive(1, 0, 0, 0, 32'h304, PRIV_M); tick();
        flags("R5", 1, 0, 1, 0);
        drive(1, 0, 0, 0, 32'h308, PRIV_M); tick();
        flags("R5", 1, 0, 0, 0);
        drive(1, 0, 1, 0, 32'h30c, PRIV_U); tick();
        flags("R5", 1, 0, 0, 0);
        drive(1, 0, 0, 0, 32'h310, PRIV_M); tick();
        flags("R5", 1, 0, 1, 0);
        idle(); tick();
    endtask

    task automatic t_trap_pending();
        drive(1, 1, 1, 0, 32'h400, PRIV_U); tick();
        flags("R6", 1, 1, 0, 0);
        drive(0, 1, 0, 0, 32'h404, PRIV_M); tick();
        flags("R6", 1, 1, 0, 0);
        chk("R6", "pc", 64'(tr_pc), 64'h404);
        idle(); tick();
        flags("R6", 0, 0, 0, 0);
        drive(1, 0, 0, 0, 32'h408, PRIV_M); tick();
        flags("R6", 1, 0, 1, 0);
        idle(); tick();
    endtask

    task automatic t_csr();
        drive(1, 0, 0, 0, 32'h500, PRIV_M);
        core_csr_we = 2'b11; core_csr_addr = {12'd4, 12'd1}; tick();
        chk("R7", "two addr", 64'(tr_csr_mask), 64'h12);
        core_csr_addr = {12'd5, 12'd5}; tick();
        chk("R7", "same addr", 64'(tr_csr_mask), 64'h20);
        core_csr_addr = {12'd3, 12'd100}; tick();
        chk("R7", "out of range", 64'(tr_csr_mask), 64'h8);
        core_csr_we = 2'b10; core_csr_addr = {12'd63, 12'd7}; tick();
        chk("R7", "port1 only", 64'(tr_csr_mask), 64'h8000_0000_0000_0000);
        core_csr_we = 2'b00; tick();
        chk("R7", "none", 64'(tr_csr_mask), 64'h0);
        chk("R7", "still valid", 64'(tr_valid), 64'h1);
        core_ret_cnt = '0; core_csr_we = 2'b01; core_csr_addr = {12'd0, 12'd2}; tick();
        chk("R11", "mask idle", 64'(tr_csr_mask), 64'h0);
        idle(); tick();
    endtask

    task automatic t_clamp();
        drive(3, 0, 0, 0, 32'h600, PRIV_M); tick();
        chk("R9", "clamped", 64'(tr_count), 64'h2);
        drive(2, 0, 0, 0, 32'h604, PRIV_M); tick();
        chk("R9", "at limit", 64'(tr_count), 64'h2);
        idle(); tick();
    endtask

    task automatic t_halt();
        drive(1, 0, 0, 1, 32'h700, PRIV_M); tick();
        flags("R10", 1, 0, 0, 1);
        chk("R10", "pc", 64'(tr_pc), 64'h700);
        drive(1, 0, 0, 0, 32'h704, PRIV_M); tick();
        flags("R10", 0, 0, 0, 0);
        drive(0, 1, 1, 0, 32'h708, PRIV_M); tick();
        flags("R10", 0, 0, 0, 0);
        drive(1, 0, 0, 0, 32'h70c, PRIV_M); tick();
        flags("R10", 0, 0, 0, 0);
        rst = 1; idle(); tick();
        rst = 0; drive(1, 0, 0, 0, 32'h710, PRIV_M); tick();
        flags("R10", 1, 0, 0, 0);
        idle(); tick();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        tick(); tick();
        t_reset();
        t_retire();
        t_trap();
        t_async();
        t_trap_pending();
        t_csr();
        t_clamp();
        t_halt();
        done = 1;
        finish_run();
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule